// File: doc/BRIEF.md
# GPS Channel Epoch Counter Unit

This block tracks the millisecond position of one GPS tracking channel within the 1 s span of the navigation data frame. It uses two cascaded counters. A fast counter steps once per code-period pulse and runs modulo 20. A slow counter steps each time the fast counter wraps and runs modulo 50. Together they cover 0 to 999 ms.

The unit has two read words, both packed the same way. The live word shows the counters as they stand now. The snapshot word holds the values captured at the most recent TIC strobe. A load word, written on a write strobe, sets the counters.

How the load is applied depends on the channel mode input. In immediate mode the write takes effect on the next clock edge. In preset mode the value is held, and the falling edge of the write strobe arms a pending preset. The counters then take the held value on the next TIC.

Top module: `gps_epoch_unit`

## Requirements
- R1: The active-low asynchronous reset clears both counters, the snapshot word and any armed preset. After reset the live and snapshot words both read 0, and a later TIC loads nothing.
- R2: With no load in effect, each cycle with `code_epoch_i` high advances the fast count by one. From 19 (or any value of 19 or above) it returns to 0.
- R3: The slow count advances by one exactly on the cycles where the fast count wraps. From 49 (or any value of 49 or above) it returns to 0.
- R4: Both read words carry the slow count in bits 13:8 and the fast count in bits 4:0. Bits 15:14 and 7:5 read 0.
- R5: On a cycle with `tic_i` high, the snapshot word takes the live word as it stood before that edge. This holds even when a pulse or a load changes the counters on the same edge. Without `tic_i` the snapshot word does not change.
- R6: In immediate mode (`preset_mode_i` = 0), a cycle with `load_we_i` high sets both counters to the load fields on the next edge. This takes precedence over a code pulse in the same cycle.
- R7: In preset mode (`preset_mode_i` = 1), a write does not change the counters: code pulses keep counting. The written value is held for later.
- R8: A preset is armed only on the cycle after a preset-mode write in which `load_we_i` is low, that is, on the falling edge of the strobe. A TIC while the strobe is still high, or a TIC in that same falling-edge cycle, applies nothing.
- R9: A TIC while a preset is armed loads the held value into both counters. This takes precedence over a code pulse in the same cycle, and the snapshot still takes the pre-load values.
- R10: Applying a preset disarms it, so a later TIC captures the snapshot without reloading the counters.
- R11: Bits 15:14 and 7:5 of the load word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_epoch_i | input | 1 | One-cycle pulse at each code period (1 ms) |
| tic_i | input | 1 | One-cycle TIC strobe |
| preset_mode_i | input | 1 | 0: immediate load, 1: load deferred to next TIC |
| load_we_i | input | 1 | Write strobe for the load word |
| load_data_i | input | 16 | Load word: slow value in 13:8, fast value in 4:0 |
| live_o | output | 16 | Current counter values, packed |
| snap_o | output | 16 | Counter values captured at last TIC, packed |

## Verification
The bench drives the cascade through the fast 19-to-0 wrap and the slow 49-to-0 wrap. A design that carried one cycle late, or that wrapped at 20 or 50, would give a live word off by one from that point on.

The preset tests aim at the timing of the arm. A TIC arrives while the strobe is still high, and another arrives in the exact cycle the strobe falls. A design that armed on the rising edge or on the level would load the counters early.

A TIC that coincides with both a code pulse and an armed preset must leave the snapshot with the pre-load values and the counters with the preset. A design that got the order wrong would show the loaded or incremented value in one word or the other. A second TIC and a reset taken mid-arm show whether the armed flag really clears.

// File: rtl/gps_epoch_pkg.sv
package gps_epoch_pkg;
  localparam int unsigned FAST_MOD = 20;
  localparam int unsigned SLOW_MOD = 50;
  localparam int unsigned FAST_W   = $clog2(FAST_MOD);
  localparam int unsigned SLOW_W   = $clog2(SLOW_MOD);
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned SLOW_LSB = 8;

  typedef struct packed {
    logic [SLOW_W-1:0] slow;
    logic [FAST_W-1:0] fast;
  } epoch_t;

  function automatic logic [WORD_W-1:0] pack_epoch(epoch_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SLOW_LSB +: SLOW_W] = e.slow;
    w[FAST_W-1:0]         = e.fast;
    return w;
  endfunction

  function automatic epoch_t unpack_epoch(logic [WORD_W-1:0] w);
    epoch_t e;
    e.slow = w[SLOW_LSB +: SLOW_W];
    e.fast = w[FAST_W-1:0];
    return e;
  endfunction
endpackage

// File: rtl/epoch_counter.sv
module epoch_counter #(
  parameter int unsigned MOD = 20,
  parameter int unsigned W   = $clog2(MOD)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] cnt_q;
  logic         at_top;

  assign at_top = (cnt_q >= TOP);
  assign wrap_o = inc_i && !load_i && at_top;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (inc_i)   cnt_q <= at_top ? '0 : cnt_q + W'(1);
  end
endmodule

// File: rtl/epoch_preset_ctrl.sv
module epoch_preset_ctrl
  import gps_epoch_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  logic   preset_mode_i,
  input  epoch_t wr_val_i,
  input  logic   tic_i,
  output epoch_t hold_o,
  output logic   apply_o
);
  epoch_t hold_q;
  logic   we_q, armed_q, arm_set;

  // arm on trailing edge of a preset-mode write
  assign arm_set = we_q && !we_i && preset_mode_i;
  assign apply_o = tic_i && armed_q;
  assign hold_o  = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      we_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      we_q <= we_i;
      if (we_i && preset_mode_i) hold_q <= wr_val_i;
      if (arm_set)      armed_q <= 1'b1;
      else if (apply_o) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/epoch_snapshot.sv
module epoch_snapshot
  import gps_epoch_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tic_i,
  input  epoch_t cur_i,
  output epoch_t snap_o
);
  epoch_t snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (tic_i) snap_q <= cur_i;
  end

  assign snap_o = snap_q;
endmodule

// File: rtl/gps_epoch_unit.sv
module gps_epoch_unit
  import gps_epoch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_epoch_i,
  input  logic              tic_i,
  input  logic              preset_mode_i,
  input  logic              load_we_i,
  input  logic [WORD_W-1:0] load_data_i,
  output logic [WORD_W-1:0] live_o,
  output logic [WORD_W-1:0] snap_o
);
  epoch_t wr_val, hold, ld_val, cur, snap;
  logic   imm_load, pre_apply, ld, fast_wrap, slow_wrap;

  assign wr_val   = unpack_epoch(load_data_i);   // drops pad bits
  assign imm_load = load_we_i && !preset_mode_i;
  assign ld       = imm_load || pre_apply;
  assign ld_val   = imm_load ? wr_val : hold;

  epoch_preset_ctrl u_pre (
    .clk_i, .rst_ni,
    .we_i(load_we_i), .preset_mode_i, .wr_val_i(wr_val), .tic_i,
    .hold_o(hold), .apply_o(pre_apply)
  );

  epoch_counter #(.MOD(FAST_MOD), .W(FAST_W)) u_fast (
    .clk_i, .rst_ni,
    .inc_i(code_epoch_i), .load_i(ld), .load_val_i(ld_val.fast),
    .cnt_o(cur.fast), .wrap_o(fast_wrap)
  );

  epoch_counter #(.MOD(SLOW_MOD), .W(SLOW_W)) u_slow (
    .clk_i, .rst_ni,
    .inc_i(fast_wrap), .load_i(ld), .load_val_i(ld_val.slow),
    .cnt_o(cur.slow), .wrap_o(slow_wrap)
  );

  epoch_snapshot u_snap (
    .clk_i, .rst_ni, .tic_i, .cur_i(cur), .snap_o(snap)
  );

  assign live_o = pack_epoch(cur);
  assign snap_o = pack_epoch(snap);
endmodule

// File: rtl/gps_epoch_unit_chk.sv
module gps_epoch_unit_chk
  import gps_epoch_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              code_epoch_i,
  input logic              tic_i,
  input logic              preset_mode_i,
  input logic              load_we_i,
  input logic [WORD_W-1:0] load_data_i,
  input logic [WORD_W-1:0] live_o,
  input logic [WORD_W-1:0] snap_o
);
  localparam logic [FAST_W-1:0] F_TOP = FAST_W'(FAST_MOD - 1);
  localparam logic [SLOW_W-1:0] S_TOP = SLOW_W'(SLOW_MOD - 1);

  p_pad_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_o[15:14] == 2'b0 && live_o[7:5] == 3'b0 && snap_o[15:14] == 2'b0 && snap_o[7:5] == 3'b0);

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_epoch_i && !tic_i && !load_we_i |=> $stable(live_o));

  p_fast_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_epoch_i && !tic_i && !load_we_i && live_o[FAST_W-1:0] == F_TOP
    |=> live_o[FAST_W-1:0] == '0);

  p_slow_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_epoch_i && !tic_i && !load_we_i && live_o[FAST_W-1:0] == F_TOP
    && live_o[SLOW_LSB +: SLOW_W] < S_TOP
    |=> live_o[SLOW_LSB +: SLOW_W] == $past(live_o[SLOW_LSB +: SLOW_W]) + SLOW_W'(1));

  p_snap_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tic_i |=> snap_o == $past(live_o));

  p_snap_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tic_i |=> $stable(snap_o));

  p_imm_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i && !preset_mode_i
    |=> live_o[SLOW_LSB +: SLOW_W] == $past(load_data_i[SLOW_LSB +: SLOW_W])
        && live_o[FAST_W-1:0] == $past(load_data_i[FAST_W-1:0]));

  p_preset_defer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_we_i && preset_mode_i && !tic_i && !code_epoch_i |=> $stable(live_o));
endmodule

bind gps_epoch_unit gps_epoch_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_epoch_i(code_epoch_i), .tic_i(tic_i),
  .preset_mode_i(preset_mode_i), .load_we_i(load_we_i), .load_data_i(load_data_i),
  .live_o(live_o), .snap_o(snap_o)
);

// File: tb/tb_gps_epoch_unit.sv
module tb_gps_epoch_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        code_epoch_i = 1'b0, tic_i = 1'b0, preset_mode_i = 1'b0, load_we_i = 1'b0;
  logic [15:0] load_data_i = '0;
  logic [15:0] live_o, snap_o;

  gps_epoch_unit dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference model
  int unsigned m_fast, m_slow, h_fast, h_slow;
  logic [15:0] m_snap;
  bit          m_arm, m_weq;

  function automatic logic [15:0] pk(int unsigned s, int unsigned f);
    logic [15:0] w;
    w = '0;
    w[13:8] = s[5:0];
    w[4:0]  = f[4:0];
    return w;
  endfunction

  task automatic model_clear();
    m_fast = 0; m_slow = 0; h_fast = 0; h_slow = 0;
    m_snap = '0; m_arm = 0; m_weq = 0;
  endtask

  task automatic step(input bit code, input bit tic, input bit mode, input bit we,
                      input logic [15:0] data, input string tag);
    bit apply, arm_n;
    @(negedge clk_i);
    code_epoch_i = code; tic_i = tic; preset_mode_i = mode; load_we_i = we; load_data_i = data;
    @(posedge clk_i);
    apply = tic && m_arm;
    arm_n = (m_weq && !we && mode) ? 1'b1 : (apply ? 1'b0 : m_arm);
    if (tic) m_snap = pk(m_slow, m_fast);
    if (we && !mode) begin
      m_fast = data[4:0]; m_slow = data[13:8];
    end else if (apply) begin
      m_fast = h_fast; m_slow = h_slow;
    end else if (code) begin
      if (m_fast >= 19) begin
        m_fast = 0;
        m_slow = (m_slow >= 49) ? 0 : m_slow + 1;
      end else m_fast = m_fast + 1;
    end
    if (we && mode) begin h_fast = data[4:0]; h_slow = data[13:8]; end
    m_arm = arm_n;
    m_weq = we;
    exp_q.push_back({m_snap, pk(m_slow, m_fast)});
    tag_q.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    code_epoch_i = 0; tic_i = 0; load_we_i = 0; preset_mode_i = 0; load_data_i = '0;
    model_clear();
    @(posedge clk_i);
    exp_q.push_back(32'h0);
    tag_q.push_back("R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // monitor
  always begin
    @(posedge clk_i);
    #1;
    while (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({snap_o, live_o} !== e) begin
        n_bad++;
        $display("FAIL %s: live=%h snap=%h expected live=%h snap=%h",
                 t, live_o, snap_o, e[15:0], e[31:16]);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    step(0, 0, 0, 0, '0, "R1 idle after reset");
    // R2/R3: count across several fast wraps
    for (int i = 0; i < 45; i++) step(1, 0, 0, 0, '0, "R2 R3 counting");
    step(0, 0, 0, 0, '0, "R2 idle hold");
    // R3: slow wrap 49 -> 0
    step(0, 0, 0, 1, pk(49, 18), "R6 immediate load");
    step(1, 0, 0, 0, '0, "R2 to 19");
    step(1, 0, 0, 0, '0, "R3 slow wrap 49->0");
    step(1, 0, 0, 0, '0, "R2 after wrap");
    // R5: tic with code pulse
    step(1, 1, 0, 0, '0, "R5 tic with code");
    step(1, 0, 0, 0, '0, "R5 snap holds");
    // R6: load beats pulse
    step(1, 0, 0, 1, pk(12, 7), "R6 load over code");
    step(1, 1, 0, 1, pk(30, 2), "R6 R5 load with tic");
    // R11: pad bits ignored
    step(0, 0, 0, 1, 16'hC0E0 | pk(7, 3), "R11 pad bits");
    step(0, 1, 0, 0, '0, "R11 R4 snap packing");
    // R7/R8/R9: preset path
    step(1, 0, 1, 1, pk(20, 10), "R7 preset write");
    step(1, 1, 1, 1, pk(21, 11), "R8 tic during strobe");
    step(1, 1, 1, 0, '0, "R8 tic at trailing edge");
    step(1, 0, 1, 0, '0, "R7 counting while armed");
    step(1, 1, 1, 0, '0, "R9 preset over code");
    step(1, 0, 1, 0, '0, "R9 after preset");
    step(0, 1, 1, 0, '0, "R10 second tic no load");
    step(1, 1, 0, 0, '0, "R10 third tic");
    // R1: reset clears armed preset
    step(0, 0, 1, 1, pk(40, 15), "R7 preset write 2");
    step(0, 0, 1, 0, '0, "R8 arm");
    do_reset();
    step(0, 1, 1, 0, '0, "R1 tic after reset no load");
    step(1, 1, 0, 0, '0, "R1 R5 follow-up");
    repeat (3) @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule